// File: doc/BRIEF.md
# Single-Cycle Control Decoder

This block turns the opcode and function fields of a 32-bit instruction word into the complete set of control levels that a single-cycle datapath needs in the same cycle. It supports a 22-instruction integer subset: register-register arithmetic and logic, immediate arithmetic and logic, load-upper-immediate, word load and store, three conditional branches, two direct jumps, a register jump and a system call.

Decoding happens in three layers. First, one line per supported instruction is raised, and at most one of them is high at a time. Second, those lines are merged into three class lines: arithmetic, logic and immediate. Third, the multi-valued control fields are encoded from the instruction and class lines. Any encoding outside the subset raises no instruction line. Every output then reads zero, so nothing writes and nothing branches. The block is purely combinational and has no clock or reset.

Top module: `ctrl_decoder`

## Requirements
- R1: Instructions are recognised by the opcode `op_i`: 0 = register format, 1 = bltz, 2 = j, 3 = jal, 4 = beq, 5 = bne, 8 = addi, 10 = slti, 12 = andi, 13 = ori, 14 = xori, 15 = lui, 35 = lw, 43 = sw. When the opcode is 0, the function field `fn_i` selects the instruction: 8 = jr, 12 = syscall, 32 = add, 34 = sub, 36 = and, 37 = or, 38 = xor, 39 = nor, 42 = slt. For any opcode other than 0, `fn_i` has no effect.
- R2: `reg_wr_o` is 1 for lui, jal, lw, the arithmetic class (add, sub, slt, addi, slti) and the logic class (and, or, xor, nor, andi, ori, xori). It is 0 for every other instruction.
- R3: `reg_dst_o` selects the destination register: 1 (rd) for the seven register-format ALU instructions, 2 (register 31) for jal, and 0 (rt) otherwise.
- R4: `wb_src_o` selects the write-back source: 2 (incremented PC) for jal, 1 (ALU result) for lui and for the arithmetic and logic classes, and 0 (memory data) otherwise.
- R5: `alu_imm_o` is 1 for lui, addi, slti, andi, ori, xori, lw and sw. It is 0 for every other instruction.
- R6: `alu_sub_o` is 1 for sub, slt and slti. It is 0 for every other instruction.
- R7: `logic_op_o` is 0 for and/andi, 1 for or/ori, 2 for xor/xori and 3 for nor. It is 0 for every other instruction.
- R8: `alu_class_o` is 0 for lui and 1 for slt/slti. It is 2 for add, sub, addi, lw and sw. It is 3 for the logic class and 0 for every other instruction.
- R9: `mem_rd_o` is 1 only for lw, and `mem_wr_o` is 1 only for sw.
- R10: `br_kind_o` is 1 for beq, 2 for bne and 3 for bltz. It is 0 for every other instruction.
- R11: `pc_sel_o` is 1 (jump target) for j and jal, 2 (register) for jr and 3 (system-call address) for syscall. It is 0 for every other instruction.
- R12: An unsupported opcode, or an unsupported function code under opcode 0, drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 6 | Opcode field of the instruction |
| fn_i | input | 6 | Function field of the instruction |
| reg_wr_o | output | 1 | Register file write enable |
| reg_dst_o | output | 2 | Destination register select |
| wb_src_o | output | 2 | Write-back data select |
| alu_imm_o | output | 1 | ALU second operand is the immediate |
| alu_sub_o | output | 1 | Adder subtracts |
| logic_op_o | output | 2 | Logic unit function |
| alu_class_o | output | 2 | ALU result class select |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| br_kind_o | output | 2 | Conditional branch kind |
| pc_sel_o | output | 2 | Next-PC source select |

## Verification
The hardest cases to reach from the ports are the register-format encodings whose function codes fall between the supported ones, and the supported function codes presented under a nonzero opcode. Both must land on the all-zero setting. A directed test that lists only the 22 legal instructions would never produce them. The bench therefore sweeps every one of the 4096 combinations of opcode and function field. It compares each control field against a table that the bench writes itself, keyed only on the numeric codes.

// File: rtl/ctrl_decoder_pkg.sv
package ctrl_decoder_pkg;

  localparam int OP_W     = 6;
  localparam int FN_W     = 6;
  localparam int N_INSTR  = 22;

  // opcodes
  localparam logic [OP_W-1:0] OPC_RTYPE = 6'd0;
  localparam logic [OP_W-1:0] OPC_BLTZ  = 6'd1;
  localparam logic [OP_W-1:0] OPC_J     = 6'd2;
  localparam logic [OP_W-1:0] OPC_JAL   = 6'd3;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'd4;
  localparam logic [OP_W-1:0] OPC_BNE   = 6'd5;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'd8;
  localparam logic [OP_W-1:0] OPC_SLTI  = 6'd10;
  localparam logic [OP_W-1:0] OPC_ANDI  = 6'd12;
  localparam logic [OP_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [OP_W-1:0] OPC_XORI  = 6'd14;
  localparam logic [OP_W-1:0] OPC_LUI   = 6'd15;
  localparam logic [OP_W-1:0] OPC_LW    = 6'd35;
  localparam logic [OP_W-1:0] OPC_SW    = 6'd43;

  // function codes under OPC_RTYPE
  localparam logic [FN_W-1:0] FNC_JR   = 6'd8;
  localparam logic [FN_W-1:0] FNC_SYS  = 6'd12;
  localparam logic [FN_W-1:0] FNC_ADD  = 6'd32;
  localparam logic [FN_W-1:0] FNC_SUB  = 6'd34;
  localparam logic [FN_W-1:0] FNC_AND  = 6'd36;
  localparam logic [FN_W-1:0] FNC_OR   = 6'd37;
  localparam logic [FN_W-1:0] FNC_XOR  = 6'd38;
  localparam logic [FN_W-1:0] FNC_NOR  = 6'd39;
  localparam logic [FN_W-1:0] FNC_SLT  = 6'd42;

  // bit positions of the one-hot instruction vector
  typedef enum int {
    I_ADD, I_SUB, I_SLT, I_AND, I_OR, I_XOR, I_NOR,
    I_LUI, I_ADDI, I_SLTI, I_ANDI, I_ORI, I_XORI,
    I_LW, I_SW, I_BLTZ, I_BEQ, I_BNE,
    I_J, I_JR, I_JAL, I_SYS
  } instr_idx_e;

  typedef logic [N_INSTR-1:0] instr_vec_t;

  typedef struct packed {
    logic arith;
    logic logic_c;
    logic imm;
    logic rfmt_alu;
  } class_t;

  // field encodings
  localparam logic [1:0] DST_RT  = 2'd0;
  localparam logic [1:0] DST_RD  = 2'd1;
  localparam logic [1:0] DST_R31 = 2'd2;

  localparam logic [1:0] WB_MEM  = 2'd0;
  localparam logic [1:0] WB_ALU  = 2'd1;
  localparam logic [1:0] WB_PC   = 2'd2;

  localparam logic [1:0] PCS_SEQ = 2'd0;
  localparam logic [1:0] PCS_JTA = 2'd1;
  localparam logic [1:0] PCS_REG = 2'd2;
  localparam logic [1:0] PCS_SYS = 2'd3;

  typedef struct packed {
    logic       reg_wr;
    logic [1:0] reg_dst;
    logic [1:0] wb_src;
    logic       alu_imm;
    logic       alu_sub;
    logic [1:0] logic_op;
    logic [1:0] alu_class;
    logic       mem_rd;
    logic       mem_wr;
    logic [1:0] br_kind;
    logic [1:0] pc_sel;
  } ctrl_t;

  // an OR over a selection of instruction lines
  function automatic logic any_of(input instr_vec_t v, input instr_vec_t mask);
    return |(v & mask);
  endfunction

  function automatic instr_vec_t bit_of(input instr_idx_e i);
    instr_vec_t m;
    m = '0;
    m[i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/instr_onehot.sv
module instr_onehot
  import ctrl_decoder_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic [FN_W-1:0] fn_i,
  output instr_vec_t      hit_o
);

  instr_vec_t rfmt_hit;
  instr_vec_t ifmt_hit;

  always_comb begin
    rfmt_hit = '0;
    unique case (fn_i)
      FNC_ADD: rfmt_hit[I_ADD] = 1'b1;
      FNC_SUB: rfmt_hit[I_SUB] = 1'b1;
      FNC_SLT: rfmt_hit[I_SLT] = 1'b1;
      FNC_AND: rfmt_hit[I_AND] = 1'b1;
      FNC_OR:  rfmt_hit[I_OR]  = 1'b1;
      FNC_XOR: rfmt_hit[I_XOR] = 1'b1;
      FNC_NOR: rfmt_hit[I_NOR] = 1'b1;
      FNC_JR:  rfmt_hit[I_JR]  = 1'b1;
      FNC_SYS: rfmt_hit[I_SYS] = 1'b1;
      default: rfmt_hit = '0;
    endcase
  end

  always_comb begin
    ifmt_hit = '0;
    unique case (op_i)
      OPC_LUI:  ifmt_hit[I_LUI]  = 1'b1;
      OPC_ADDI: ifmt_hit[I_ADDI] = 1'b1;
      OPC_SLTI: ifmt_hit[I_SLTI] = 1'b1;
      OPC_ANDI: ifmt_hit[I_ANDI] = 1'b1;
      OPC_ORI:  ifmt_hit[I_ORI]  = 1'b1;
      OPC_XORI: ifmt_hit[I_XORI] = 1'b1;
      OPC_LW:   ifmt_hit[I_LW]   = 1'b1;
      OPC_SW:   ifmt_hit[I_SW]   = 1'b1;
      OPC_BLTZ: ifmt_hit[I_BLTZ] = 1'b1;
      OPC_BEQ:  ifmt_hit[I_BEQ]  = 1'b1;
      OPC_BNE:  ifmt_hit[I_BNE]  = 1'b1;
      OPC_J:    ifmt_hit[I_J]    = 1'b1;
      OPC_JAL:  ifmt_hit[I_JAL]  = 1'b1;
      default:  ifmt_hit = '0;
    endcase
  end

  assign hit_o = (op_i == OPC_RTYPE) ? rfmt_hit : ifmt_hit;

endmodule

// File: rtl/instr_class.sv
module instr_class
  import ctrl_decoder_pkg::*;
(
  input  instr_vec_t hit_i,
  output class_t     cls_o
);

  localparam instr_vec_t M_ARITH = bit_of(I_ADD) | bit_of(I_SUB) | bit_of(I_SLT)
                                 | bit_of(I_ADDI) | bit_of(I_SLTI);
  localparam instr_vec_t M_LOGIC = bit_of(I_AND) | bit_of(I_OR) | bit_of(I_XOR)
                                 | bit_of(I_NOR) | bit_of(I_ANDI) | bit_of(I_ORI)
                                 | bit_of(I_XORI);
  localparam instr_vec_t M_IMM   = bit_of(I_LUI) | bit_of(I_ADDI) | bit_of(I_SLTI)
                                 | bit_of(I_ANDI) | bit_of(I_ORI) | bit_of(I_XORI);
  localparam instr_vec_t M_RALU  = bit_of(I_ADD) | bit_of(I_SUB) | bit_of(I_SLT)
                                 | bit_of(I_AND) | bit_of(I_OR) | bit_of(I_XOR)
                                 | bit_of(I_NOR);

  assign cls_o.arith    = any_of(hit_i, M_ARITH);
  assign cls_o.logic_c  = any_of(hit_i, M_LOGIC);
  assign cls_o.imm      = any_of(hit_i, M_IMM);
  assign cls_o.rfmt_alu = any_of(hit_i, M_RALU);

endmodule

// File: rtl/ctrl_encode.sv
module ctrl_encode
  import ctrl_decoder_pkg::*;
(
  input  instr_vec_t hit_i,
  input  class_t     cls_i,
  output ctrl_t      ctrl_o
);

  logic is_lui, is_lw, is_sw, is_jal;
  assign is_lui = hit_i[I_LUI];
  assign is_lw  = hit_i[I_LW];
  assign is_sw  = hit_i[I_SW];
  assign is_jal = hit_i[I_JAL];

  always_comb begin
    ctrl_o = '0;

    ctrl_o.reg_wr  = is_lui | cls_i.arith | cls_i.logic_c | is_lw | is_jal;
    ctrl_o.alu_imm = cls_i.imm | is_lw | is_sw;
    ctrl_o.alu_sub = hit_i[I_SUB] | hit_i[I_SLT] | hit_i[I_SLTI];
    ctrl_o.mem_rd  = is_lw;
    ctrl_o.mem_wr  = is_sw;

    if (is_jal)              ctrl_o.reg_dst = DST_R31;
    else if (cls_i.rfmt_alu) ctrl_o.reg_dst = DST_RD;
    else                     ctrl_o.reg_dst = DST_RT;

    if (is_jal)                                   ctrl_o.wb_src = WB_PC;
    else if (is_lui | cls_i.arith | cls_i.logic_c) ctrl_o.wb_src = WB_ALU;
    else                                          ctrl_o.wb_src = WB_MEM;

    ctrl_o.logic_op[1] = hit_i[I_XOR] | hit_i[I_XORI] | hit_i[I_NOR];
    ctrl_o.logic_op[0] = hit_i[I_OR]  | hit_i[I_ORI]  | hit_i[I_NOR];

    ctrl_o.alu_class[1] = hit_i[I_ADD] | hit_i[I_SUB] | hit_i[I_ADDI]
                        | is_lw | is_sw | cls_i.logic_c;
    ctrl_o.alu_class[0] = hit_i[I_SLT] | hit_i[I_SLTI] | cls_i.logic_c;

    ctrl_o.br_kind[1] = hit_i[I_BNE] | hit_i[I_BLTZ];
    ctrl_o.br_kind[0] = hit_i[I_BEQ] | hit_i[I_BLTZ];

    if (hit_i[I_SYS])                 ctrl_o.pc_sel = PCS_SYS;
    else if (hit_i[I_JR])             ctrl_o.pc_sel = PCS_REG;
    else if (hit_i[I_J] | is_jal)     ctrl_o.pc_sel = PCS_JTA;
    else                              ctrl_o.pc_sel = PCS_SEQ;
  end

endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
  import ctrl_decoder_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic [FN_W-1:0] fn_i,
  output logic            reg_wr_o,
  output logic [1:0]      reg_dst_o,
  output logic [1:0]      wb_src_o,
  output logic            alu_imm_o,
  output logic            alu_sub_o,
  output logic [1:0]      logic_op_o,
  output logic [1:0]      alu_class_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic [1:0]      br_kind_o,
  output logic [1:0]      pc_sel_o
);

  instr_vec_t hit_w;
  class_t     cls_w;
  ctrl_t      ctrl_w;

  instr_onehot u_onehot (.op_i(op_i), .fn_i(fn_i), .hit_o(hit_w));
  instr_class  u_class  (.hit_i(hit_w), .cls_o(cls_w));
  ctrl_encode  u_encode (.hit_i(hit_w), .cls_i(cls_w), .ctrl_o(ctrl_w));

  assign reg_wr_o    = ctrl_w.reg_wr;
  assign reg_dst_o   = ctrl_w.reg_dst;
  assign wb_src_o    = ctrl_w.wb_src;
  assign alu_imm_o   = ctrl_w.alu_imm;
  assign alu_sub_o   = ctrl_w.alu_sub;
  assign logic_op_o  = ctrl_w.logic_op;
  assign alu_class_o = ctrl_w.alu_class;
  assign mem_rd_o    = ctrl_w.mem_rd;
  assign mem_wr_o    = ctrl_w.mem_wr;
  assign br_kind_o   = ctrl_w.br_kind;
  assign pc_sel_o    = ctrl_w.pc_sel;

endmodule

// File: rtl/ctrl_decoder_chk.sv
module ctrl_decoder_chk
  import ctrl_decoder_pkg::*;
(
  input instr_vec_t hit_w,
  input class_t     cls_w,
  input logic       reg_wr_o,
  input logic [1:0] reg_dst_o,
  input logic [1:0] wb_src_o,
  input logic       alu_imm_o,
  input logic       alu_sub_o,
  input logic [1:0] logic_op_o,
  input logic [1:0] alu_class_o,
  input logic       mem_rd_o,
  input logic       mem_wr_o,
  input logic [1:0] br_kind_o,
  input logic [1:0] pc_sel_o
);

  always_comb begin
    p_single_instr_r1: assert ($onehot0(hit_w))
      else $error("more than one instruction line high");
    p_load_writes_r2: assert (!mem_rd_o || (reg_wr_o && wb_src_o == WB_MEM))
      else $error("load without register write from memory");
    p_link_r3: assert (reg_dst_o != DST_R31 || (wb_src_o == WB_PC && pc_sel_o == PCS_JTA))
      else $error("link destination without link data or jump");
    p_dst_code_r3: assert (reg_dst_o != 2'd3)
      else $error("undefined destination code");
    p_imm_not_rd_r5: assert (!(alu_imm_o && reg_dst_o == DST_RD))
      else $error("immediate operand with rd destination");
    p_logic_class_r7: assert (logic_op_o == 2'd0 || alu_class_o == 2'd3)
      else $error("logic function outside logic class");
    p_mem_excl_r9: assert (!(mem_rd_o && mem_wr_o))
      else $error("read and write together");
    p_branch_quiet_r10: assert (br_kind_o == 2'd0 || (!reg_wr_o && pc_sel_o == PCS_SEQ && !mem_wr_o))
      else $error("branch with side effects");
    p_unsup_zero_r12: assert (hit_w != '0 || ({reg_wr_o, reg_dst_o, wb_src_o, alu_imm_o,
                              alu_sub_o, logic_op_o, alu_class_o, mem_rd_o, mem_wr_o,
                              br_kind_o, pc_sel_o} == '0 && cls_w == '0))
      else $error("unsupported encoding not quiet");
  end

endmodule

bind ctrl_decoder ctrl_decoder_chk u_chk (
  .hit_w(hit_w), .cls_w(cls_w),
  .reg_wr_o(reg_wr_o), .reg_dst_o(reg_dst_o), .wb_src_o(wb_src_o),
  .alu_imm_o(alu_imm_o), .alu_sub_o(alu_sub_o), .logic_op_o(logic_op_o),
  .alu_class_o(alu_class_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
  .br_kind_o(br_kind_o), .pc_sel_o(pc_sel_o)
);

// File: tb/ctrl_decoder_bench.sv
module ctrl_decoder_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [5:0] op, fn;
  logic       reg_wr, alu_imm, alu_sub, mem_rd, mem_wr;
  logic [1:0] reg_dst, wb_src, logic_op, alu_class, br_kind, pc_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  ctrl_decoder u_ctrl_decoder (
    .op_i(op), .fn_i(fn),
    .reg_wr_o(reg_wr), .reg_dst_o(reg_dst), .wb_src_o(wb_src),
    .alu_imm_o(alu_imm), .alu_sub_o(alu_sub), .logic_op_o(logic_op),
    .alu_class_o(alu_class), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .br_kind_o(br_kind), .pc_sel_o(pc_sel)
  );

  // expected fields, named by mnemonic string from the numeric codes (R1)
  function automatic string name_of(input int o, input int f);
    if (o == 0) begin
      case (f)
        32: return "add";  34: return "sub";  42: return "slt";
        36: return "and";  37: return "or";   38: return "xor";
        39: return "nor";  8:  return "jr";   12: return "syscall";
        default: return "";
      endcase
    end
    case (o)
      1: return "bltz"; 2: return "j"; 3: return "jal"; 4: return "beq";
      5: return "bne"; 8: return "addi"; 10: return "slti"; 12: return "andi";
      13: return "ori"; 14: return "xori"; 15: return "lui"; 35: return "lw";
      43: return "sw";
      default: return "";
    endcase
  endfunction

  function automatic bit in_set(input string n, input string s[]);
    foreach (s[k]) if (s[k] == n) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string req, input int act, input int exp, input int o, input int f);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s op=%0d fn=%0d actual=%0d expected=%0d", req, o, f, act, exp);
    end
  endtask

  task automatic check_one(input int o, input int f);
    string n;
    int e_wr, e_dst, e_wb, e_imm, e_sub, e_lop, e_cls, e_rd, e_mw, e_br, e_pc;
    n = name_of(o, f);
    e_wr  = in_set(n, '{"add","sub","slt","and","or","xor","nor","lui","addi",
                       "slti","andi","ori","xori","lw","jal"});
    e_dst = (n == "jal") ? 2 : in_set(n, '{"add","sub","slt","and","or","xor","nor"}) ? 1 : 0;
    e_wb  = (n == "jal") ? 2 : (e_wr != 0 && n != "lw") ? 1 : 0;
    e_imm = in_set(n, '{"lui","addi","slti","andi","ori","xori","lw","sw"});
    e_sub = in_set(n, '{"sub","slt","slti"});
    e_lop = in_set(n, '{"or","ori"}) ? 1 : in_set(n, '{"xor","xori"}) ? 2 : (n == "nor") ? 3 : 0;
    e_cls = in_set(n, '{"slt","slti"}) ? 1 :
            in_set(n, '{"add","sub","addi","lw","sw"}) ? 2 :
            in_set(n, '{"and","or","xor","nor","andi","ori","xori"}) ? 3 : 0;
    e_rd  = (n == "lw");
    e_mw  = (n == "sw");
    e_br  = (n == "beq") ? 1 : (n == "bne") ? 2 : (n == "bltz") ? 3 : 0;
    e_pc  = in_set(n, '{"j","jal"}) ? 1 : (n == "jr") ? 2 : (n == "syscall") ? 3 : 0;
    if (n == "") begin
      // R12: everything quiet for unsupported encodings
      chk("R12", int'({reg_wr, reg_dst, wb_src, alu_imm, alu_sub, logic_op,
                       alu_class, mem_rd, mem_wr, br_kind, pc_sel}), 0, o, f);
    end
    chk("R2",  int'(reg_wr),    e_wr,  o, f);
    chk("R3",  int'(reg_dst),   e_dst, o, f);
    chk("R4",  int'(wb_src),    e_wb,  o, f);
    chk("R5",  int'(alu_imm),   e_imm, o, f);
    chk("R6",  int'(alu_sub),   e_sub, o, f);
    chk("R7",  int'(logic_op),  e_lop, o, f);
    chk("R8",  int'(alu_class), e_cls, o, f);
    chk("R9",  int'({mem_rd, mem_wr}), e_rd * 2 + e_mw, o, f);
    chk("R10", int'(br_kind),   e_br,  o, f);
    chk("R11", int'(pc_sel),    e_pc,  o, f);
  endtask

  initial begin
    op = 6'd63; fn = 6'd63;
    @(negedge clk);
    // initial state with an unsupported word: all outputs zero (R12)
    check_one(63, 63);
    // R1: full sweep, including supported function codes under nonzero opcodes
    for (int o = 0; o < 64; o++) begin
      for (int f = 0; f < 64; f++) begin
        @(posedge clk);
        op = 6'(o); fn = 6'(f);
        @(negedge clk);
        check_one(o, f);
      end
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 10000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule